// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block generates the system reset for a processor subsystem. Its inputs are voltage-good flags that are already digital and synchronous to the block clock: main supply good, auxiliary sense good and power-fail good. It also takes an active-low manual reset pin and a watchdog kick pin, and both of these pass through two-flop synchronizers. Any fault holds the active-low system reset low. Once every fault has cleared, a down-counter keeps reset low for a programmable number of clock cycles before it releases.

A watchdog counter starts when reset releases. Each edge of the kick pin, rising or falling, restarts it. If no edge arrives in time, the watchdog fires a one-cycle fault, which gives a full stretched reset and reloads the watchdog. A build-time mode selects how the sense flag is used. In the combined mode it joins the system reset. In the dual mode it drives its own stretched reset output. The power-fail flag bypasses all reset logic and reaches its output with no delay. Every pin is a plain level signal, with no handshake and no back-pressure.

Top module: `rst_supervisor`

## Requirements
- R1: While `arst_n` is low, `sys_rst_n` and `sense_rst_n` are low and the hold counters sit at HOLD_CYCLES.
- R2: `sys_rst_n` rises exactly HOLD_CYCLES clock edges after the last cycle with a system fault. If `supply_ok` has been low and is driven high, reset is still low after HOLD_CYCLES-1 edges and high after HOLD_CYCLES edges.
- R3: In the same cycle that `supply_ok` goes low, `sys_rst_n` goes low, with no register in the path.
- R4: A low on `man_rst_n` reaches the logic after 2 clock edges and then forces `sys_rst_n` low whatever the voltage flags are. After the pin returns high, `sys_rst_n` rises 2+HOLD_CYCLES edges later.
- R5: In combined mode (OUT_MODE = OUT_COMBINED), a low `sense_ok` forces `sys_rst_n` low in the same cycle, release follows the R2 timing, and `sense_rst_n` always equals `sys_rst_n`.
- R6: In dual mode (OUT_MODE = OUT_DUAL), a low `sense_ok` forces `sense_rst_n` low in the same cycle and leaves `sys_rst_n` unaffected. `sense_rst_n` has its own HOLD_CYCLES release delay. A supply fault or a watchdog expiry leaves `sense_rst_n` high. A synchronized manual reset forces both outputs low.
- R7: Both rising and falling edges of `wdi`, taken after its 2-flop synchronizer, restart the watchdog count. Toggling `wdi` at intervals shorter than WDOG_CYCLES keeps `sys_rst_n` high.
- R8: With no kick edges, `sys_rst_n` stays high for exactly WDOG_CYCLES cycles after release. It is then low for HOLD_CYCLES+1 cycles, after which a fresh WDOG_CYCLES window begins.
- R9: `pfail_n` equals `pfail_ok` AND the synchronized manual reset level, with no delay. `pfail_ok` has no effect on either reset output.
- R10: The watchdog counter is held at zero while the system hold counter is not idle, so a reset of any length is followed by a full WDOG_CYCLES window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Main supply above threshold (synchronous flag) |
| sense_ok | input | 1 | Auxiliary sense input above reference (synchronous flag) |
| pfail_ok | input | 1 | Power-fail input above reference (synchronous flag) |
| man_rst_n | input | 1 | Manual reset pin, active low, asynchronous |
| wdi | input | 1 | Watchdog kick pin, asynchronous, either edge |
| sys_rst_n | output | 1 | Stretched system reset, active low |
| sense_rst_n | output | 1 | Sense reset, active low (mirror of sys_rst_n in combined mode) |
| pfail_n | output | 1 | Undelayed power-fail flag, active low |

## Verification
A table of flag and manual-reset combinations is applied to a dual-mode instance and a combined-mode instance side by side. Each settled output is compared against a truth table, which separates the ORed sense path from the independent one and shows that power-fail leaves reset alone. Directed edge-counted tests then place the release of each fault source exactly at HOLD_CYCLES, or at 2+HOLD_CYCLES for the manual pin. That catches an off-by-one in the counter or a missing synchronizer stage. The watchdog is run unkicked after a long reset to measure the high and low windows. It is then kicked at two-thirds of the timeout with alternating polarity, which exposes a detector that sees only one edge type.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic {
    OUT_COMBINED = 1'b0,
    OUT_DUAL     = 1'b1
  } out_mode_e;
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic fault_i,
  output logic rst_n_o,
  output logic idle_o
);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYCLES);

  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              cnt_q <= HOLD_LOAD;
    else if (fault_i)         cnt_q <= HOLD_LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o  = (cnt_q == '0);
  assign rst_n_o = !fault_i && idle_o;

  // R2
  reload_on_fault_chk: assert property (@(posedge clk) disable iff (!arst_n)
    fault_i |=> (cnt_q == HOLD_LOAD));

  // R2
  release_after_count_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> ($past(cnt_q) == HOLD_W'(1)) && !$past(fault_i));
endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
  parameter int WDOG_CYCLES = 40
) (
  input  logic clk,
  input  logic arst_n,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int WD_W = $clog2(WDOG_CYCLES + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYCLES);

  logic [WD_W-1:0] cnt_q;
  logic            kick_prev_q;
  logic            kick_edge;
  logic            at_limit;

  assign kick_edge = kick_i ^ kick_prev_q;
  assign at_limit  = (cnt_q == WD_LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      kick_prev_q <= 1'b0;
      cnt_q       <= '0;
    end else begin
      kick_prev_q <= kick_i;
      if (!run_i || kick_edge || at_limit) cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = run_i && !kick_edge && at_limit;

  // R10
  held_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !run_i |=> (cnt_q == '0));

  // R7
  kick_restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (run_i && kick_edge) |=> (cnt_q == '0));

  // R8
  expire_only_running_chk: assert property (@(posedge clk) disable iff (!arst_n)
    expire_o |-> run_i && (cnt_q == WD_LAST));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int                   HOLD_CYCLES = 200000,
  parameter int                   WDOG_CYCLES = 1600000,
  parameter int                   SYNC_STAGES = 2,
  parameter rsup_pkg::out_mode_e  OUT_MODE    = rsup_pkg::OUT_DUAL
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok,
  input  logic sense_ok,
  input  logic pfail_ok,
  input  logic man_rst_n,
  input  logic wdi,
  output logic sys_rst_n,
  output logic sense_rst_n,
  output logic pfail_n
);
  localparam bit DUAL = (OUT_MODE == rsup_pkg::OUT_DUAL);

  logic man_n_s;
  logic kick_s;
  logic wd_expire;
  logic sys_idle;
  logic sys_fault;
  logic sense_in_sys;

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_man_sync (
    .clk(clk), .arst_n(arst_n), .d_i(man_rst_n), .q_o(man_n_s));

  rsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_kick_sync (
    .clk(clk), .arst_n(arst_n), .d_i(wdi), .q_o(kick_s));

  rsup_wdog #(.WDOG_CYCLES(WDOG_CYCLES)) u_wdog (
    .clk(clk), .arst_n(arst_n), .run_i(sys_idle), .kick_i(kick_s),
    .expire_o(wd_expire));

  assign sense_in_sys = DUAL ? 1'b0 : !sense_ok;
  assign sys_fault    = !supply_ok || !man_n_s || wd_expire || sense_in_sys;

  rsup_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_sys_hold (
    .clk(clk), .arst_n(arst_n), .fault_i(sys_fault),
    .rst_n_o(sys_rst_n), .idle_o(sys_idle));

  generate
    if (DUAL) begin : g_dual
      logic sense_fault;
      logic sense_idle;
      assign sense_fault = !sense_ok || !man_n_s;
      rsup_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_sense_hold (
        .clk(clk), .arst_n(arst_n), .fault_i(sense_fault),
        .rst_n_o(sense_rst_n), .idle_o(sense_idle));

      // R6
      sense_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !sense_ok |-> !sense_rst_n);
    end else begin : g_comb
      assign sense_rst_n = sys_rst_n;

      // R5
      comb_sense_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !sense_ok |-> !sys_rst_n);
    end
  endgenerate

  assign pfail_n = pfail_ok && man_n_s;

  // R3
  supply_drop_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |-> !sys_rst_n);

  // R4
  manual_force_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !man_n_s |-> !sys_rst_n && !sense_rst_n && !pfail_n);

  // R9
  pfail_follow_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (man_n_s && !pfail_ok) |-> !pfail_n);
endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 8;
  localparam int WDOG = 40;
  localparam int MAX_CYCLES = 100000;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic supply_ok = 1'b1, sense_ok = 1'b1, pfail_ok = 1'b1;
  logic man_rst_n = 1'b1, wdi = 1'b0;
  logic d_sys, d_sen, d_pf, c_sys, c_sen, c_pf;

  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_supervisor #(.HOLD_CYCLES(HOLD), .WDOG_CYCLES(WDOG),
                   .OUT_MODE(rsup_pkg::OUT_DUAL)) i_rst_supervisor (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .sense_ok(sense_ok),
    .pfail_ok(pfail_ok), .man_rst_n(man_rst_n), .wdi(wdi),
    .sys_rst_n(d_sys), .sense_rst_n(d_sen), .pfail_n(d_pf));

  rst_supervisor #(.HOLD_CYCLES(HOLD), .WDOG_CYCLES(WDOG),
                   .OUT_MODE(rsup_pkg::OUT_COMBINED)) i_rst_supervisor_comb (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .sense_ok(sense_ok),
    .pfail_ok(pfail_ok), .man_rst_n(man_rst_n), .wdi(wdi),
    .sys_rst_n(c_sys), .sense_rst_n(c_sen), .pfail_n(c_pf));

  // inputs {supply, sense, pfail, man_n}, dual {sys, sense, pf}, comb {sys, sense, pf}
  localparam logic [9:0] VEC [8] = '{
    10'b1111_111_111,
    10'b0111_011_001,
    10'b1011_101_001,
    10'b1101_110_110,
    10'b0001_000_000,
    10'b1110_000_000,
    10'b1000_000_000,
    10'b1111_111_111
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic kick();
    @(negedge clk);
    wdi = ~wdi;
  endtask

  task automatic wait_release();
    for (int k = 0; k < 60; k++) begin
      if (d_sys === 1'b1) break;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    logic bad;
    // R1: power-on reset state
    repeat (3) @(negedge clk);
    check("R1 dual sys", d_sys, 1'b0);
    check("R1 dual sense", d_sen, 1'b0);
    check("R1 comb sys", c_sys, 1'b0);
    arst_n = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    check("R1 still held", d_sys, 1'b0);
    @(negedge clk);
    check("R1 released", d_sys, 1'b1);

    // truth-table walk (R5 R6 R9)
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {supply_ok, sense_ok, pfail_ok, man_rst_n} = VEC[v][9:6];
      wdi = ~wdi;
      repeat (14) @(negedge clk);
      check("R6 vec dual sys", d_sys, VEC[v][5]);
      check("R6 vec dual sense", d_sen, VEC[v][4]);
      check("R9 vec dual pf", d_pf, VEC[v][3]);
      check("R5 vec comb sys", c_sys, VEC[v][2]);
      check("R5 vec comb sense", c_sen, VEC[v][1]);
      check("R9 vec comb pf", c_pf, VEC[v][0]);
    end

    // R3 immediate drop, R2 release timing
    kick();
    @(negedge clk); supply_ok = 1'b0; #1;
    check("R3 immediate drop", d_sys, 1'b0);
    check("R6 supply leaves sense", d_sen, 1'b1);
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    check("R2 held at HOLD-1", d_sys, 1'b0);
    @(negedge clk);
    check("R2 release at HOLD", d_sys, 1'b1);

    // R4 manual reset
    kick();
    @(negedge clk); man_rst_n = 1'b0;
    @(negedge clk);
    check("R4 sync stage 1", d_sys, 1'b1);
    @(negedge clk);
    check("R4 sync stage 2", d_sys, 1'b0);
    check("R6 manual forces sense", d_sen, 1'b0);
    man_rst_n = 1'b1;
    repeat (2 + HOLD - 1) @(negedge clk);
    check("R4 held", d_sys, 1'b0);
    @(negedge clk);
    check("R4 release", d_sys, 1'b1);

    // R6/R5 sense path
    kick();
    @(negedge clk); sense_ok = 1'b0; #1;
    check("R6 sense drop", d_sen, 1'b0);
    check("R6 sys unaffected", d_sys, 1'b1);
    check("R5 comb drop", c_sys, 1'b0);
    @(negedge clk); sense_ok = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    check("R6 sense held", d_sen, 1'b0);
    check("R5 comb held", c_sys, 1'b0);
    @(negedge clk);
    check("R6 sense release", d_sen, 1'b1);
    check("R5 comb release", c_sys, 1'b1);

    // R9 power fail direct
    kick();
    @(negedge clk); pfail_ok = 1'b0; #1;
    check("R9 pfail low", d_pf, 1'b0);
    check("R9 reset untouched", d_sys, 1'b1);
    @(negedge clk); pfail_ok = 1'b1; #1;
    check("R9 pfail high", d_pf, 1'b1);

    // R10 + R8: long reset, then unkicked watchdog windows
    @(negedge clk); supply_ok = 1'b0;
    repeat (60) @(negedge clk);
    supply_ok = 1'b1;
    @(negedge clk);
    wait_release();
    bad = 1'b0;
    n = 0;
    while (d_sys === 1'b1 && n < 200) begin
      if (d_sen !== 1'b1 || c_sys !== d_sys) bad = 1'b1;
      n++; @(negedge clk);
    end
    check("R10 full window after reset", n == WDOG, 1'b1);
    n = 0;
    while (d_sys === 1'b0 && n < 200) begin
      if (d_sen !== 1'b1 || c_sys !== d_sys) bad = 1'b1;
      n++; @(negedge clk);
    end
    check("R8 low HOLD+1", n == HOLD + 1, 1'b1);
    n = 0;
    while (d_sys === 1'b1 && n < 200) begin n++; @(negedge clk); end
    check("R8 reinit window", n == WDOG, 1'b1);
    check("R6 wdog leaves sense / R5 comb agrees", bad, 1'b0);

    // R7 kicks of both polarities keep reset high
    wait_release();
    bad = 1'b0;
    for (int t = 0; t < 7; t++) begin
      wdi = ~wdi;
      for (int c = 0; c < 26; c++) begin
        @(negedge clk);
        if (d_sys !== 1'b1) bad = 1'b1;
      end
    end
    check("R7 both edges kick", bad, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule